// File: doc/BRIEF.md
# Projection Panel Scan Timing Generator

This block derives every scan-control waveform that a polysilicon TFT projection panel with on-glass shift registers needs from one master clock. The waveforms are a horizontal start pulse, a complementary horizontal clock pair, a vertical start pulse, a vertical clock, a gate-enable window, a precharge pulse and a black-frame pulse. It follows the incoming horizontal and vertical sync. A rising HSYNC edge opens a new line. A rising VSYNC edge arms a new frame, and the frame begins at the next line start. Every pulse position inside a line is a parameter counted in master-clock ticks from the line start.

Three configuration inputs choose the options. The first selects the tall (full) active area or the shorter 8:5 area, which stays centred on the screen. The other two select left-to-right or right-to-left horizontal scan, and top-to-bottom or bottom-to-top vertical scan. The block samples all three at frame start, drives them back out to the panel, and uses them to set the start-pulse phases. It also toggles a line-rate flag that the video path uses for line-by-line polarity inversion. The block has no data stream, so it has no handshake. All pins are plain control levels that are valid on every cycle.

Top module: `lcdtg_panel_timing`

## Requirements
- R1: While reset is held, and after it until the first HSYNC rise, the outputs are quiet: start pulses, gate enable, precharge, black and the positive horizontal clock are 0. The negative horizontal clock is 1. The vertical clock and the inversion flag are 0. The area, right and down outputs are 1.
- R2: A rising HSYNC edge sampled on a clock edge sets the line tick to 0 at that edge. This happens even when the previous line was shorter than its nominal length. The tick then advances by one per clock.
- R3: The horizontal clock pair is always complementary. The video window runs from tick H_START for H_CLOCKS periods of 2·2^HALF_LOG2 ticks, each half 2^HALF_LOG2 ticks long. In right scan the positive clock is high in the first half of each period; in left scan it is low. Outside the window the positive clock is 0.
- R4: The horizontal start pulse lasts one clock period. In right scan it starts one full period before H_START. In left scan it starts half a period before H_START.
- R5: The vertical clock toggles at every line start and at no other time.
- R6: The inversion flag toggles at every line start and at no other time.
- R7: Gate enable is high from tick ENB_AT up to, but not including, tick H_END+ENB_TAIL, where H_END is the end of the video window.
- R8: The internal precharge pulse is high for PCG_W ticks, starting PCG_GAP ticks after gate enable falls. The precharge output is this pulse ORed with the black output.
- R9: Black is high on frame lines BLK_AT to BLK_AT+BLK_LINES-1. Line 0 is the frame-start line.
- R10: The first active line is V_FIRST for the tall area and V_FIRST+(FULL_LINES-SHORT_LINES)/2 for the short area. In down scan the vertical start is high for the whole line before the first active line. In up scan it is high from tick VST_SPLIT of that line until tick VST_SPLIT of the first active line.
- R11: The area, right and down outputs, and every timing that depends on them, change only at a frame start. At that point they take the configuration input values.
- R12: A frame starts at the first HSYNC rise at or after a VSYNC rise. The two may be simultaneous, or VSYNC may rise earlier within the previous line.
- R13: Gate enable and the internal precharge pulse are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync | input | 1 | Horizontal sync, rising edge starts a line |
| vsync | input | 1 | Vertical sync, rising edge arms a frame start |
| cfg_full_area | input | 1 | 1 = tall area, 0 = short centred area |
| cfg_scan_right | input | 1 | 1 = right scan, 0 = left scan |
| cfg_scan_down | input | 1 | 1 = down scan, 0 = up scan |
| h_start_o | output | 1 | Horizontal start pulse |
| h_clk_p_o | output | 1 | Horizontal clock, positive phase |
| h_clk_n_o | output | 1 | Horizontal clock, negative phase |
| v_start_o | output | 1 | Vertical start pulse |
| v_clk_o | output | 1 | Vertical clock, toggles per line |
| gate_en_o | output | 1 | Gate enable window |
| precharge_o | output | 1 | Precharge pulse ORed with black |
| black_o | output | 1 | Black-frame pulse |
| area_full_o | output | 1 | Latched area select |
| scan_right_o | output | 1 | Latched horizontal direction |
| scan_down_o | output | 1 | Latched vertical direction |
| video_inv_o | output | 1 | Line polarity flag |

## Verification
Every output is decoded from registers that update on the clock edge where the HSYNC rise is sampled. After edge k+n, the outputs therefore show tick n of the line, and a frame start changes the configuration outputs at edge k itself. The driver raises HSYNC on a falling edge and, at the same moment, queues the expected output word for the following rising edge. The monitor samples one nanosecond after each rising edge and compares against the queue head, so each expected word lines up with exactly one tick. Truncated lines, early VSYNC and a configuration change in mid-frame all pass through the same queue alignment.

// File: rtl/lcdtg_pkg.sv
package lcdtg_pkg;

  typedef struct packed {
    logic full_area;
    logic scan_right;
    logic scan_down;
  } scan_cfg_t;

  localparam scan_cfg_t CFG_RESET = '{full_area: 1'b1, scan_right: 1'b1, scan_down: 1'b1};

endpackage

// File: rtl/lcdtg_sync_edge.sv
module lcdtg_sync_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);

  logic [N-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl;
  end

  // rising edge of each sync level, same cycle as the input
  assign rise = lvl & ~lvl_q;

endmodule

// File: rtl/lcdtg_line_timer.sv
module lcdtg_line_timer #(
  parameter int HPOS_W    = 11,
  parameter int HALF_LOG2 = 2,
  parameter int H_CLOCKS  = 134,
  parameter int H_START   = 32,
  parameter int ENB_AT    = 16,
  parameter int ENB_TAIL  = 16,
  parameter int PCG_GAP   = 4,
  parameter int PCG_W     = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              scan_right,
  output logic [HPOS_W-1:0] hpos,
  output logic              h_start,
  output logic              hck_p,
  output logic              hck_n,
  output logic              gate_en,
  output logic              pcg_pulse,
  output logic              v_clk,
  output logic              video_inv
);

  localparam int HALF    = 1 << HALF_LOG2;
  localparam int HPER    = 2 * HALF;
  localparam int H_END   = H_START + H_CLOCKS * HPER;
  localparam int ENB_OFF = H_END + ENB_TAIL;
  localparam int PCG_ON  = ENB_OFF + PCG_GAP;
  localparam int PCG_OFF = PCG_ON + PCG_W;
  localparam int HST_R   = H_START - HPER;
  localparam int HST_L   = H_START - HALF;

  localparam logic [HPOS_W-1:0] HPOS_MAX  = '1;
  localparam logic [HPOS_W-1:0] VID_ON_P  = HPOS_W'(H_START);
  localparam logic [HPOS_W-1:0] VID_OFF_P = HPOS_W'(H_END);
  localparam logic [HPOS_W-1:0] ENB_ON_P  = HPOS_W'(ENB_AT);
  localparam logic [HPOS_W-1:0] ENB_OFF_P = HPOS_W'(ENB_OFF);
  localparam logic [HPOS_W-1:0] PCG_ON_P  = HPOS_W'(PCG_ON);
  localparam logic [HPOS_W-1:0] PCG_OFF_P = HPOS_W'(PCG_OFF);
  localparam logic [HPOS_W-1:0] HSTR_ON_P = HPOS_W'(HST_R);
  localparam logic [HPOS_W-1:0] HSTR_OFF_P= HPOS_W'(HST_R + HPER);
  localparam logic [HPOS_W-1:0] HSTL_ON_P = HPOS_W'(HST_L);
  localparam logic [HPOS_W-1:0] HSTL_OFF_P= HPOS_W'(HST_L + HPER);
  localparam logic [HPOS_W-1:0] HALF_MASK = HPOS_W'(HALF);

  // tick counter: restarts on each line start, parks at all-ones
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hpos      <= HPOS_MAX;
      v_clk     <= 1'b0;
      video_inv <= 1'b0;
    end else if (line_start) begin
      hpos      <= '0;
      v_clk     <= ~v_clk;
      video_inv <= ~video_inv;
    end else if (hpos != HPOS_MAX) begin
      hpos <= hpos + 1'b1;
    end
  end

  logic              in_video;
  logic [HPOS_W-1:0] vid_off;
  logic              second_half;
  logic [HPOS_W-1:0] hst_lo;
  logic [HPOS_W-1:0] hst_hi;

  always_comb begin
    in_video    = (hpos >= VID_ON_P) && (hpos < VID_OFF_P);
    vid_off     = hpos - VID_ON_P;
    second_half = |(vid_off & HALF_MASK);
    // right scan: positive phase leads; left scan: it trails
    hck_p       = in_video && (second_half ^ scan_right);
    hck_n       = ~hck_p;
    hst_lo      = scan_right ? HSTR_ON_P  : HSTL_ON_P;
    hst_hi      = scan_right ? HSTR_OFF_P : HSTL_OFF_P;
    h_start     = (hpos >= hst_lo) && (hpos < hst_hi);
    gate_en     = (hpos >= ENB_ON_P) && (hpos < ENB_OFF_P);
    pcg_pulse   = (hpos >= PCG_ON_P) && (hpos < PCG_OFF_P);
  end

endmodule

// File: rtl/lcdtg_frame_seq.sv
module lcdtg_frame_seq import lcdtg_pkg::*; #(
  parameter int HPOS_W      = 11,
  parameter int VLINE_W     = 10,
  parameter int FULL_LINES  = 604,
  parameter int SHORT_LINES = 500,
  parameter int V_FIRST     = 20,
  parameter int BLK_AT      = 4,
  parameter int BLK_LINES   = 8,
  parameter int VST_SPLIT   = 600
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_start,
  input  logic               frame_arm,
  input  scan_cfg_t          cfg_in,
  input  logic [HPOS_W-1:0]  hpos,
  output scan_cfg_t          cfg_q,
  output logic [VLINE_W-1:0] vline,
  output logic               frame_start,
  output logic               black,
  output logic               v_start
);

  localparam int CENTER_SHIFT = (FULL_LINES - SHORT_LINES) / 2;

  localparam logic [VLINE_W-1:0] VLINE_MAX   = '1;
  localparam logic [VLINE_W-1:0] ACT_FULL_P  = VLINE_W'(V_FIRST);
  localparam logic [VLINE_W-1:0] ACT_SHORT_P = VLINE_W'(V_FIRST + CENTER_SHIFT);
  localparam logic [VLINE_W-1:0] BLK_ON_P    = VLINE_W'(BLK_AT);
  localparam logic [VLINE_W-1:0] BLK_OFF_P   = VLINE_W'(BLK_AT + BLK_LINES);
  localparam logic [HPOS_W-1:0]  SPLIT_P     = HPOS_W'(VST_SPLIT);

  logic armed;

  assign frame_start = line_start && (armed || frame_arm);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      vline <= VLINE_MAX;
      cfg_q <= CFG_RESET;
    end else if (line_start) begin
      armed <= 1'b0;
      if (frame_start) begin
        vline <= '0;
        cfg_q <= cfg_in;   // options switch only here
      end else if (vline != VLINE_MAX) begin
        vline <= vline + 1'b1;
      end
    end else if (frame_arm) begin
      armed <= 1'b1;
    end
  end

  logic [VLINE_W-1:0] act_line;
  logic [VLINE_W-1:0] lead_line;

  always_comb begin
    act_line  = cfg_q.full_area ? ACT_FULL_P : ACT_SHORT_P;
    lead_line = act_line - 1'b1;
    black     = (vline >= BLK_ON_P) && (vline < BLK_OFF_P);
    if (cfg_q.scan_down)
      v_start = (vline == lead_line);
    else
      v_start = ((vline == lead_line) && (hpos >= SPLIT_P)) ||
                ((vline == act_line)  && (hpos <  SPLIT_P));
  end

endmodule

// File: rtl/lcdtg_panel_timing.sv
module lcdtg_panel_timing import lcdtg_pkg::*; #(
  parameter int HPOS_W      = 11,
  parameter int VLINE_W     = 10,
  parameter int HALF_LOG2   = 2,
  parameter int H_CLOCKS    = 134,
  parameter int H_START     = 32,
  parameter int ENB_AT      = 16,
  parameter int ENB_TAIL    = 16,
  parameter int PCG_GAP     = 4,
  parameter int PCG_W       = 36,
  parameter int FULL_LINES  = 604,
  parameter int SHORT_LINES = 500,
  parameter int V_FIRST     = 20,
  parameter int BLK_AT      = 4,
  parameter int BLK_LINES   = 8,
  parameter int VST_SPLIT   = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync,
  input  logic vsync,
  input  logic cfg_full_area,
  input  logic cfg_scan_right,
  input  logic cfg_scan_down,
  output logic h_start_o,
  output logic h_clk_p_o,
  output logic h_clk_n_o,
  output logic v_start_o,
  output logic v_clk_o,
  output logic gate_en_o,
  output logic precharge_o,
  output logic black_o,
  output logic area_full_o,
  output logic scan_right_o,
  output logic scan_down_o,
  output logic video_inv_o
);

  logic [1:0]         sync_rise;
  logic               line_start;
  logic               frame_arm;
  logic [HPOS_W-1:0]  hpos;
  logic [VLINE_W-1:0] vline;
  logic               pcg_pulse;
  logic               frame_start;
  scan_cfg_t          cfg_in;
  scan_cfg_t          cfg_q;

  assign cfg_in = '{full_area: cfg_full_area, scan_right: cfg_scan_right,
                    scan_down: cfg_scan_down};

  lcdtg_sync_edge #(.N(2)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  ({vsync, hsync}),
    .rise (sync_rise)
  );

  assign line_start = sync_rise[0];
  assign frame_arm  = sync_rise[1];

  lcdtg_line_timer #(
    .HPOS_W(HPOS_W), .HALF_LOG2(HALF_LOG2), .H_CLOCKS(H_CLOCKS),
    .H_START(H_START), .ENB_AT(ENB_AT), .ENB_TAIL(ENB_TAIL),
    .PCG_GAP(PCG_GAP), .PCG_W(PCG_W)
  ) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_start(line_start),
    .scan_right(cfg_q.scan_right),
    .hpos      (hpos),
    .h_start   (h_start_o),
    .hck_p     (h_clk_p_o),
    .hck_n     (h_clk_n_o),
    .gate_en   (gate_en_o),
    .pcg_pulse (pcg_pulse),
    .v_clk     (v_clk_o),
    .video_inv (video_inv_o)
  );

  lcdtg_frame_seq #(
    .HPOS_W(HPOS_W), .VLINE_W(VLINE_W), .FULL_LINES(FULL_LINES),
    .SHORT_LINES(SHORT_LINES), .V_FIRST(V_FIRST), .BLK_AT(BLK_AT),
    .BLK_LINES(BLK_LINES), .VST_SPLIT(VST_SPLIT)
  ) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .frame_arm  (frame_arm),
    .cfg_in     (cfg_in),
    .hpos       (hpos),
    .cfg_q      (cfg_q),
    .vline      (vline),
    .frame_start(frame_start),
    .black      (black_o),
    .v_start    (v_start_o)
  );

  assign precharge_o  = pcg_pulse | black_o;
  assign area_full_o  = cfg_q.full_area;
  assign scan_right_o = cfg_q.scan_right;
  assign scan_down_o  = cfg_q.scan_down;

endmodule

// File: rtl/lcdtg_panel_timing_chk.sv
module lcdtg_panel_timing_chk #(
  parameter int HPOS_W    = 11,
  parameter int VLINE_W   = 10,
  parameter int HALF_LOG2 = 2,
  parameter int H_CLOCKS  = 134,
  parameter int H_START   = 32,
  parameter int ENB_AT    = 16,
  parameter int ENB_TAIL  = 16,
  parameter int BLK_AT    = 4,
  parameter int BLK_LINES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               line_start,
  input logic               frame_start,
  input logic [HPOS_W-1:0]  hpos,
  input logic [VLINE_W-1:0] vline,
  input logic               pcg_pulse,
  input logic               h_start_o,
  input logic               h_clk_p_o,
  input logic               h_clk_n_o,
  input logic               v_clk_o,
  input logic               gate_en_o,
  input logic               precharge_o,
  input logic               black_o,
  input logic               area_full_o,
  input logic               scan_right_o,
  input logic               scan_down_o,
  input logic               video_inv_o
);

  localparam int H_END = H_START + H_CLOCKS * 2 * (1 << HALF_LOG2);

  assert_clk_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    h_clk_p_o != h_clk_n_o);

  assert_clk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((hpos < HPOS_W'(H_START)) || (hpos >= HPOS_W'(H_END))) |-> !h_clk_p_o);

  assert_hst_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(h_start_o) |=> h_start_o);

  assert_vclk_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (v_clk_o != $past(v_clk_o)));

  assert_vclk_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(v_clk_o));

  assert_inv_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (video_inv_o != $past(video_inv_o)));

  assert_enb_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en_o) |-> (hpos == HPOS_W'(ENB_AT)));

  assert_enb_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_en_o) |-> ((hpos == HPOS_W'(H_END + ENB_TAIL)) || (hpos == '0)));

  assert_black_in_pcg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    black_o |-> precharge_o);

  assert_black_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(black_o) |-> (vline == VLINE_W'(BLK_AT)));

  assert_black_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(black_o) |-> ((vline == VLINE_W'(BLK_AT + BLK_LINES)) || (vline == '0)));

  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable({area_full_o, scan_right_o, scan_down_o}));

  assert_frame_on_line_R12: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> line_start);

  assert_no_overlap_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_en_o && pcg_pulse));

endmodule

bind lcdtg_panel_timing lcdtg_panel_timing_chk #(
  .HPOS_W(HPOS_W), .VLINE_W(VLINE_W), .HALF_LOG2(HALF_LOG2),
  .H_CLOCKS(H_CLOCKS), .H_START(H_START), .ENB_AT(ENB_AT),
  .ENB_TAIL(ENB_TAIL), .BLK_AT(BLK_AT), .BLK_LINES(BLK_LINES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start),
  .frame_start(frame_start), .hpos(hpos), .vline(vline),
  .pcg_pulse(pcg_pulse), .h_start_o(h_start_o), .h_clk_p_o(h_clk_p_o),
  .h_clk_n_o(h_clk_n_o), .v_clk_o(v_clk_o), .gate_en_o(gate_en_o),
  .precharge_o(precharge_o), .black_o(black_o), .area_full_o(area_full_o),
  .scan_right_o(scan_right_o), .scan_down_o(scan_down_o),
  .video_inv_o(video_inv_o)
);

// File: tb/lcdtg_panel_timing_test.sv
`timescale 1ns/1ps
module lcdtg_panel_timing_test;

  localparam int HALF_LOG2 = 1;
  localparam int HALF   = 2;
  localparam int HPER   = 4;
  localparam int HCLKS  = 6;
  localparam int HS     = 8;
  localparam int EA     = 3;
  localparam int ET     = 2;
  localparam int PG     = 1;
  localparam int PW     = 3;
  localparam int FULLN  = 10;
  localparam int SHORTN = 6;
  localparam int VF     = 8;
  localparam int BA     = 2;
  localparam int BL     = 3;
  localparam int SPLIT  = 10;
  localparam int HE     = HS + HCLKS * HPER;
  localparam int LINE   = 44;

  logic clk = 1'b0;
  logic rst_n, hsync, vsync, cfg_full, cfg_right, cfg_down;
  logic h_start_o, h_clk_p_o, h_clk_n_o, v_start_o, v_clk_o, gate_en_o;
  logic precharge_o, black_o, area_full_o, scan_right_o, scan_down_o, video_inv_o;

  always #2 clk = ~clk;

  lcdtg_panel_timing #(
    .HPOS_W(8), .VLINE_W(6), .HALF_LOG2(HALF_LOG2), .H_CLOCKS(HCLKS),
    .H_START(HS), .ENB_AT(EA), .ENB_TAIL(ET), .PCG_GAP(PG), .PCG_W(PW),
    .FULL_LINES(FULLN), .SHORT_LINES(SHORTN), .V_FIRST(VF), .BLK_AT(BA),
    .BLK_LINES(BL), .VST_SPLIT(SPLIT)
  ) uut (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .cfg_full_area(cfg_full), .cfg_scan_right(cfg_right), .cfg_scan_down(cfg_down),
    .h_start_o(h_start_o), .h_clk_p_o(h_clk_p_o), .h_clk_n_o(h_clk_n_o),
    .v_start_o(v_start_o), .v_clk_o(v_clk_o), .gate_en_o(gate_en_o),
    .precharge_o(precharge_o), .black_o(black_o), .area_full_o(area_full_o),
    .scan_right_o(scan_right_o), .scan_down_o(scan_down_o),
    .video_inv_o(video_inv_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [11:0] expq[$];

  // reference state
  int mline = 1000;
  bit mvck = 0, mpol = 0, mpend = 0;
  bit mfull = 1, mright = 1, mdown = 1;

  function automatic string fname(int i);
    case (i)
      11: return "h_start R4";      10: return "h_clk_p R2,R3";
      9:  return "h_clk_n R3";      8:  return "v_start R10,R12";
      7:  return "v_clk R5";        6:  return "gate_en R2,R7";
      5:  return "precharge R8";    4:  return "black R9,R12";
      3:  return "area R11";        2:  return "right R11";
      1:  return "down R11";        default: return "video_inv R6";
    endcase
  endfunction

  function automatic logic [11:0] expect_at(int h, int l);
    bit vid, fh, p, hs_b, vs_b, enb, pp, blk;
    int hon, act;
    vid  = (h >= HS) && (h < HE);
    fh   = ((h - HS) % HPER) < HALF;
    p    = vid && (fh == mright);
    hon  = mright ? HS - HPER : HS - HALF;
    hs_b = (h >= hon) && (h < hon + HPER);
    act  = mfull ? VF : VF + (FULLN - SHORTN) / 2;
    if (mdown) vs_b = (l == act - 1);
    else       vs_b = ((l == act - 1) && (h >= SPLIT)) || ((l == act) && (h < SPLIT));
    enb  = (h >= EA) && (h < HE + ET);
    pp   = (h >= HE + ET + PG) && (h < HE + ET + PG + PW);
    blk  = (l >= BA) && (l < BA + BL);
    return {hs_b, p, !p, vs_b, mvck, enb, pp | blk, blk, mfull, mright, mdown, mpol};
  endfunction

  task automatic chk(string tag, logic got, logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic run_line(int len, bit fs, bit vs_late);
    for (int t = 0; t < len; t++) begin
      @(negedge clk);
      hsync = (t < 2);
      vsync = fs ? (t < 2) : (vs_late && t >= 20 && t < 24);
      if (t == 0) begin
        mvck = !mvck;
        mpol = !mpol;
        if (mpend || fs) begin
          mline = 0; mfull = cfg_full; mright = cfg_right; mdown = cfg_down; mpend = 0;
        end else begin
          mline++;
        end
      end
      if (vs_late && t == 20) mpend = 1;
      expq.push_back(expect_at(t, mline));
    end
  endtask

  // monitor: compare one expected word per tick
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expq.size() > 0) begin
        logic [11:0] e, g;
        e = expq.pop_front();
        g = {h_start_o, h_clk_p_o, h_clk_n_o, v_start_o, v_clk_o, gate_en_o,
             precharge_o, black_o, area_full_o, scan_right_o, scan_down_o, video_inv_o};
        for (int i = 0; i < 12; i++) begin
          n_cmp++;
          if (g[i] !== e[i]) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", fname(i), g[i], e[i]);
          end
        end
        if (!e[4]) chk("R13 gate/precharge overlap", gate_en_o && precharge_o, 1'b0);
      end
    end
  end

  task automatic check_quiet();
    chk("R1 h_start", h_start_o, 1'b0);    chk("R1 h_clk_p", h_clk_p_o, 1'b0);
    chk("R1 h_clk_n", h_clk_n_o, 1'b1);    chk("R1 v_start", v_start_o, 1'b0);
    chk("R1 v_clk", v_clk_o, 1'b0);        chk("R1 gate_en", gate_en_o, 1'b0);
    chk("R1 precharge", precharge_o, 1'b0); chk("R1 black", black_o, 1'b0);
    chk("R1 area", area_full_o, 1'b1);     chk("R1 right", scan_right_o, 1'b1);
    chk("R1 down", scan_down_o, 1'b1);     chk("R1 video_inv", video_inv_o, 1'b0);
  endtask

  initial begin
    rst_n = 0; hsync = 0; vsync = 0;
    cfg_full = 0; cfg_right = 0; cfg_down = 0;
    repeat (3) @(negedge clk);
    check_quiet();
    rst_n = 1;
    repeat (2) @(negedge clk);
    check_quiet();

    // frame A: tall, right, down; config changes mid-frame (R11)
    cfg_full = 1; cfg_right = 1; cfg_down = 1;
    run_line(LINE, 1, 0);
    for (int l = 1; l < 20; l++) begin
      if (l == 5) begin cfg_full = 0; cfg_right = 0; cfg_down = 0; end
      run_line(LINE, 0, l == 19);
    end

    // frame B: short, left, up; started by early vsync (R12), truncated lines (R2)
    for (int l = 0; l < 20; l++)
      run_line((l == 3) ? 20 : ((l == 15) ? 30 : LINE), 0, 0);

    // frame C: tall, left, down
    cfg_full = 1; cfg_right = 0; cfg_down = 1;
    run_line(LINE, 1, 0);
    for (int l = 1; l < 20; l++) run_line(LINE, 0, 0);

    // frame D: short, right, up
    cfg_full = 0; cfg_right = 1; cfg_down = 0;
    run_line(LINE, 1, 0);
    for (int l = 1; l < 20; l++) run_line(LINE, 0, 0);

    @(negedge clk); hsync = 0; vsync = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule